// File: doc/BRIEF.md
# Dual-Issue Reservation Station with Oldest-First Selection

This block sits in front of one shared execution unit that holds two integer pipes. Each cycle it can accept one dispatched instruction. The instruction carries an opcode, an age stamp and two source operands. Each operand arrives either as a value or as the tag of the instruction that will produce it. Entries then wait in the station until both operands hold values. A single result bus broadcasts a tag and a value, and every waiting operand whose tag matches takes that value.

Each cycle the station looks at the entries whose operands are complete and issues up to two of them. Issue does not follow dispatch order, so a younger entry that is ready leaves ahead of an older one that is still waiting. When more entries are ready than there are issue ports, the oldest ones win. A flush input gives an age, and every entry younger than that age is discarded. This lets a mispredicted path be removed without draining the station.

Top module: `resv_station_dual`

## Requirements
- R1: After reset no entry is occupied: `full` is low and both issue ports are idle.
- R2: An entry dispatched with both operands marked ready can issue in the cycle after dispatch. The issue port presents its opcode and both operand values.
- R3: An entry with a pending operand does not issue. When `res_valid` carries the matching tag, the operand takes `res_value`, and the entry can issue in the following cycle with that value.
- R4: A younger entry whose operands are complete issues even while an older entry is still waiting on a tag.
- R5: When several entries are ready, issue port 0 takes the oldest and port 1 takes the next oldest. Port 1 is never active while port 0 is idle.
- R6: A pending operand whose tag equals the tag broadcast in the same cycle as its dispatch takes the broadcast value at dispatch.
- R7: `full` is high exactly when all six entries are occupied. A dispatch offered while `full` is high is dropped and never issues.
- R8: A slot freed by issue can be allocated again from the next cycle on. `full` falls in the cycle after an issue from a full station.
- R9: With `flush_valid` high, every entry whose age is younger than `flush_age` is discarded in that cycle and does not issue. An entry is younger when (age − flush_age) mod 32 lies in 1..15. Entries that are equal or older stay. A younger dispatch in the same cycle is dropped.
- R10: Each issue port selects a distinct, occupied entry, and an entry leaves through at most one port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | 8 | Opcode of the dispatched instruction |
| disp_age | input | 5 | Age stamp, increasing in program order, wrapping |
| disp_a_rdy | input | 1 | Operand A carries a value |
| disp_a_tag | input | 4 | Producer tag of operand A when not ready |
| disp_a_val | input | 16 | Value of operand A when ready |
| disp_b_rdy | input | 1 | Operand B carries a value |
| disp_b_tag | input | 4 | Producer tag of operand B when not ready |
| disp_b_val | input | 16 | Value of operand B when ready |
| full | output | 1 | No free entry; dispatch is dropped |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | 4 | Tag of the broadcast result |
| res_value | input | 16 | Broadcast result value |
| flush_valid | input | 1 | Discard entries younger than flush_age |
| flush_age | input | 5 | Age boundary for flush |
| iss_valid | output | 2 | Per-port issue valid, bit 0 = oldest |
| iss_op | output | 16 | Opcodes, port p at bits [8p+7:8p] |
| iss_a | output | 32 | Operand A values, port p at [16p+15:16p] |
| iss_b | output | 32 | Operand B values, port p at [16p+15:16p] |

## Verification
Two kinds of event can land in the same cycle here. A result broadcast can coincide with the dispatch of an instruction waiting on that tag. A flush can coincide with selection of a ready entry it makes stale. The bench provokes both on purpose by driving a matching tag with a dispatch, and by raising flush in the very cycle two woken entries become eligible. A behavioural queue model decides which entry must capture, survive or issue, and every output is compared against it each cycle.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
   // true when cand lies strictly after ref_age in a wrapping window of half the range
   function automatic logic age_is_younger(input logic [31:0] cand,
                                           input logic [31:0] ref_age,
                                           input int unsigned width);
      logic [31:0] mask;
      logic [31:0] diff;
      mask = (32'd1 << width) - 32'd1;
      diff = (cand - ref_age) & mask;
      return (diff != 32'd0) && (diff < (32'd1 << (width - 1)));
   endfunction
endpackage

// File: rtl/rs_operand_slot.sv
`timescale 1ns/1ps
module rs_operand_slot #(
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              ld_rdy,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [DATA_W-1:0] ld_val,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              rdy,
   output logic [DATA_W-1:0] val
);
   logic [TAG_W-1:0] tag_q;
   logic             ld_hit;
   logic             wait_hit;

   assign ld_hit   = bc_valid && !ld_rdy && (ld_tag == bc_tag);
   assign wait_hit = bc_valid && !rdy && (tag_q == bc_tag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy   <= 1'b0;
         tag_q <= '0;
         val   <= '0;
      end else if (load) begin
         rdy   <= ld_rdy | ld_hit;
         tag_q <= ld_tag;
         val   <= ld_hit ? bc_val : ld_val;
      end else if (wait_hit) begin
         rdy   <= 1'b1;
         val   <= bc_val;
      end
   end
endmodule

// File: rtl/rs_free_pick.sv
`timescale 1ns/1ps
module rs_free_pick #(
   parameter int N = 6
) (
   input  logic [N-1:0] busy,
   output logic [N-1:0] pick_oh,
   output logic         full
);
   logic found;
   always_comb begin
      pick_oh = '0;
      found   = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!busy[i] && !found) begin
            pick_oh[i] = 1'b1;
            found      = 1'b1;
         end
      end
      full = &busy;
   end
endmodule

// File: rtl/rs_age_select.sv
`timescale 1ns/1ps
module rs_age_select #(
   parameter int N       = 6,
   parameter int ISSUE_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         alloc_oh,
   input  logic [N-1:0]         busy,
   input  logic [N-1:0]         elig,
   output logic [ISSUE_W*N-1:0] grant_flat
);
   // older_q[i][j] set: entry j was dispatched before entry i
   logic [N-1:0] older_q [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) older_q[i] <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (alloc_oh[i]) older_q[i] <= busy;
            else             older_q[i] <= older_q[i] & ~alloc_oh;
         end
      end
   end

   for (genvar p = 0; p < ISSUE_W; p++) begin : g_port
      logic [N-1:0] avail;
      logic [N-1:0] won;
      logic [N-1:0] left;
      if (p == 0) begin : g_head
         assign avail = elig;
      end else begin : g_tail
         assign avail = g_port[p-1].left;
      end
      for (genvar i = 0; i < N; i++) begin : g_ent
         assign won[i] = avail[i] & ~|(avail & older_q[i]);
      end
      assign left = avail & ~won;
      assign grant_flat[p*N +: N] = won;
   end
endmodule

// File: rtl/resv_station_dual.sv
`timescale 1ns/1ps
module resv_station_dual
   import rs_pkg::*;
#(
   parameter int ENTRIES = 6,
   parameter int ISSUE_W = 2,
   parameter int OP_W    = 8,
   parameter int DATA_W  = 16,
   parameter int TAG_W   = 4,
   parameter int AGE_W   = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      disp_valid,
   input  logic [OP_W-1:0]           disp_op,
   input  logic [AGE_W-1:0]          disp_age,
   input  logic                      disp_a_rdy,
   input  logic [TAG_W-1:0]          disp_a_tag,
   input  logic [DATA_W-1:0]         disp_a_val,
   input  logic                      disp_b_rdy,
   input  logic [TAG_W-1:0]          disp_b_tag,
   input  logic [DATA_W-1:0]         disp_b_val,
   output logic                      full,
   input  logic                      res_valid,
   input  logic [TAG_W-1:0]          res_tag,
   input  logic [DATA_W-1:0]         res_value,
   input  logic                      flush_valid,
   input  logic [AGE_W-1:0]          flush_age,
   output logic [ISSUE_W-1:0]        iss_valid,
   output logic [ISSUE_W*OP_W-1:0]   iss_op,
   output logic [ISSUE_W*DATA_W-1:0] iss_a,
   output logic [ISSUE_W*DATA_W-1:0] iss_b
);
   localparam int GRANT_W = ISSUE_W * ENTRIES;

   if (ENTRIES < 2)                       $error("ENTRIES must be at least 2");
   if (ISSUE_W < 1 || ISSUE_W > ENTRIES)  $error("ISSUE_W out of range");
   if (AGE_W > 31)                        $error("AGE_W too wide");
   if (AGE_W < $clog2(ENTRIES) + 2)       $error("AGE_W too narrow for the window");

   logic [ENTRIES-1:0]       busy_q, alloc_oh, load, kill, elig, issued, rdy_a, rdy_b;
   logic [OP_W-1:0]          op_q   [ENTRIES];
   logic [AGE_W-1:0]         age_q  [ENTRIES];
   logic [DATA_W-1:0]        val_a  [ENTRIES];
   logic [DATA_W-1:0]        val_b  [ENTRIES];
   logic [ENTRIES*AGE_W-1:0] age_flat;
   logic [GRANT_W-1:0]       grant_flat;
   logic [ISSUE_W*AGE_W-1:0] pick_age_flat;
   logic                     disp_drop, do_alloc;

   rs_free_pick #(.N(ENTRIES)) u_free (
      .busy    (busy_q),
      .pick_oh (alloc_oh),
      .full    (full)
   );

   assign disp_drop = flush_valid &&
                      age_is_younger(32'(disp_age), 32'(flush_age), AGE_W);
   assign do_alloc  = disp_valid && !full && !disp_drop;
   assign load      = do_alloc ? alloc_oh : '0;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             busy_r;
      logic [OP_W-1:0]  op_r;
      logic [AGE_W-1:0] age_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_r <= 1'b0;
            op_r   <= '0;
            age_r  <= '0;
         end else if (load[e]) begin
            busy_r <= 1'b1;
            op_r   <= disp_op;
            age_r  <= disp_age;
         end else if (kill[e] || issued[e]) begin
            busy_r <= 1'b0;
         end
      end

      assign busy_q[e] = busy_r;
      assign op_q[e]   = op_r;
      assign age_q[e]  = age_r;
      assign age_flat[e*AGE_W +: AGE_W] = age_r;
      assign kill[e]   = busy_r && flush_valid &&
                         age_is_younger(32'(age_r), 32'(flush_age), AGE_W);
      assign elig[e]   = busy_r && rdy_a[e] && rdy_b[e] && !kill[e];

      rs_operand_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_opa (
         .clk (clk), .rst_n (rst_n), .load (load[e]),
         .ld_rdy (disp_a_rdy), .ld_tag (disp_a_tag), .ld_val (disp_a_val),
         .bc_valid (res_valid), .bc_tag (res_tag), .bc_val (res_value),
         .rdy (rdy_a[e]), .val (val_a[e])
      );
      rs_operand_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_opb (
         .clk (clk), .rst_n (rst_n), .load (load[e]),
         .ld_rdy (disp_b_rdy), .ld_tag (disp_b_tag), .ld_val (disp_b_val),
         .bc_valid (res_valid), .bc_tag (res_tag), .bc_val (res_value),
         .rdy (rdy_b[e]), .val (val_b[e])
      );
   end

   rs_age_select #(.N(ENTRIES), .ISSUE_W(ISSUE_W)) u_age (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_oh   (load),
      .busy       (busy_q),
      .elig       (elig),
      .grant_flat (grant_flat)
   );

   always_comb begin
      iss_valid     = '0;
      iss_op        = '0;
      iss_a         = '0;
      iss_b         = '0;
      issued        = '0;
      pick_age_flat = '0;
      for (int p = 0; p < ISSUE_W; p++) begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (grant_flat[p*ENTRIES + e]) begin
               iss_valid[p]                       = 1'b1;
               issued[e]                          = 1'b1;
               iss_op[p*OP_W +: OP_W]             = op_q[e];
               iss_a[p*DATA_W +: DATA_W]          = val_a[e];
               iss_b[p*DATA_W +: DATA_W]          = val_b[e];
               pick_age_flat[p*AGE_W +: AGE_W]    = age_q[e];
            end
         end
      end
   end
endmodule

// File: rtl/rs_station_chk.sv
`timescale 1ns/1ps
module rs_station_chk
   import rs_pkg::*;
#(
   parameter int ENTRIES = 6,
   parameter int ISSUE_W = 2,
   parameter int AGE_W   = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ENTRIES-1:0]         busy,
   input  logic [ENTRIES*AGE_W-1:0]   ages,
   input  logic                       full,
   input  logic                       disp_valid,
   input  logic [ISSUE_W*ENTRIES-1:0] grant_flat,
   input  logic [ISSUE_W-1:0]         iss_valid,
   input  logic [ISSUE_W*AGE_W-1:0]   pick_age,
   input  logic                       flush_valid,
   input  logic [AGE_W-1:0]           flush_age
);
   logic [ENTRIES-1:0] granted_any;
   logic [ENTRIES-1:0] stale_young;
   logic [AGE_W-1:0]   flush_age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flush_age_q <= '0;
      else        flush_age_q <= flush_age;
   end

   always_comb begin
      granted_any = '0;
      for (int p = 0; p < ISSUE_W; p++)
         granted_any = granted_any | grant_flat[p*ENTRIES +: ENTRIES];
      for (int e = 0; e < ENTRIES; e++)
         stale_young[e] = busy[e] &&
            age_is_younger(32'(ages[e*AGE_W +: AGE_W]), 32'(flush_age_q), AGE_W);
   end

   p_grant_unique_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant_flat) == $countones(iss_valid));

   p_grant_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (granted_any & ~busy) == '0);

   p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && disp_valid) |=> ($countones(busy) <= $past($countones(busy))));

   p_flush_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> (stale_young == '0));

   if (ISSUE_W > 1) begin : g_pair
      p_port_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[1] |-> iss_valid[0]);

      p_age_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[1] |-> age_is_younger(32'(pick_age[AGE_W +: AGE_W]),
                                         32'(pick_age[0 +: AGE_W]), AGE_W));
   end
endmodule

bind resv_station_dual rs_station_chk #(
   .ENTRIES (ENTRIES),
   .ISSUE_W (ISSUE_W),
   .AGE_W   (AGE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy_q),
   .ages        (age_flat),
   .full        (full),
   .disp_valid  (disp_valid),
   .grant_flat  (grant_flat),
   .iss_valid   (iss_valid),
   .pick_age    (pick_age_flat),
   .flush_valid (flush_valid),
   .flush_age   (flush_age)
);

// File: tb/resv_station_dual_bench.sv
`timescale 1ns/1ps
module resv_station_dual_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        full;
   logic [1:0]  iss_valid;
   logic [15:0] iss_op;
   logic [31:0] iss_a, iss_b;

   logic        d_v = 0, d_ra = 0, d_rb = 0;
   logic [7:0]  d_op = 0;
   logic [3:0]  d_ta = 0, d_tb = 0;
   logic [15:0] d_va = 0, d_vb = 0;
   logic        b_v = 0;
   logic [3:0]  b_tag = 0;
   logic [15:0] b_val = 0;
   logic        f_v = 0;
   int          d_seq = 0, f_seq = 0, seq = 0;
   int          checks = 0, errors = 0;
   string       cur_req = "R1";
   bit          done = 0;

   typedef struct {
      int          sq;
      logic [7:0]  op;
      bit          ra, rb;
      logic [3:0]  ta, tb;
      logic [15:0] va, vb;
   } ment_t;
   ment_t mq[$];

   always #10 clk = ~clk;

   resv_station_dual u_resv_station_dual (
      .clk (clk), .rst_n (rst_n),
      .disp_valid (d_v), .disp_op (d_op), .disp_age (d_seq[4:0]),
      .disp_a_rdy (d_ra), .disp_a_tag (d_ta), .disp_a_val (d_va),
      .disp_b_rdy (d_rb), .disp_b_tag (d_tb), .disp_b_val (d_vb),
      .full (full),
      .res_valid (b_v), .res_tag (b_tag), .res_value (b_val),
      .flush_valid (f_v), .flush_age (f_seq[4:0]),
      .iss_valid (iss_valid), .iss_op (iss_op), .iss_a (iss_a), .iss_b (iss_b)
   );

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
      end
   endtask

   // one clock of the reference model: predict, compare, advance
   task automatic tick();
      ment_t       nq[$];
      ment_t       m;
      int          n_iss;
      bit          killed;
      logic [1:0]  ev;
      logic [7:0]  eop[2];
      logic [15:0] ea[2], eb[2];
      #2;
      n_iss = 0; ev = 0;
      foreach (mq[i]) begin
         m = mq[i];
         killed = f_v && (m.sq > f_seq);
         if (!killed && m.ra && m.rb && n_iss < 2) begin
            ev[n_iss] = 1; eop[n_iss] = m.op; ea[n_iss] = m.va; eb[n_iss] = m.vb;
            n_iss++;
         end else if (!killed) begin
            if (b_v && !m.ra && m.ta == b_tag) begin m.ra = 1; m.va = b_val; end
            if (b_v && !m.rb && m.tb == b_tag) begin m.rb = 1; m.vb = b_val; end
            nq.push_back(m);
         end
      end
      chk("full", {31'd0, full}, {31'd0, mq.size() == 6});
      chk("iss_valid", {30'd0, iss_valid}, {30'd0, ev});
      for (int p = 0; p < 2; p++) begin
         if (ev[p]) begin
            chk($sformatf("op%0d", p), {24'd0, iss_op[p*8 +: 8]}, {24'd0, eop[p]});
            chk($sformatf("a%0d", p), {16'd0, iss_a[p*16 +: 16]}, {16'd0, ea[p]});
            chk($sformatf("b%0d", p), {16'd0, iss_b[p*16 +: 16]}, {16'd0, eb[p]});
         end
      end
      if (rst_n && d_v && mq.size() < 6 && !(f_v && d_seq > f_seq)) begin
         m.sq = d_seq; m.op = d_op;
         m.ra = d_ra; m.ta = d_ta; m.va = d_va;
         m.rb = d_rb; m.tb = d_tb; m.vb = d_vb;
         if (b_v && !m.ra && m.ta == b_tag) begin m.ra = 1; m.va = b_val; end
         if (b_v && !m.rb && m.tb == b_tag) begin m.rb = 1; m.vb = b_val; end
         nq.push_back(m);
      end
      mq = nq;
      @(negedge clk);
   endtask

   task automatic idle();
      d_v = 0; b_v = 0; f_v = 0;
   endtask

   task automatic step();
      tick();
      idle();
   endtask

   task automatic disp(logic [7:0] op, bit ra, logic [3:0] ta, logic [15:0] va,
                       bit rb, logic [3:0] tb, logic [15:0] vb);
      d_v = 1; d_op = op; d_seq = seq; seq++;
      d_ra = ra; d_ta = ta; d_va = va; d_rb = rb; d_tb = tb; d_vb = vb;
   endtask

   task automatic bcast(logic [3:0] t, logic [15:0] v);
      b_v = 1; b_tag = t; b_val = v;
   endtask

   task automatic drain();
      for (int t = 0; t < 16; t++) begin
         bcast(4'(t), 16'hD000 + 16'(t));
         step();
      end
      for (int k = 0; k < 4; k++) step();
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL %s watchdog actual=running expected=finished", cur_req);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      cur_req = "R1";
      step(); step();
      rst_n = 1;
      step(); step();

      cur_req = "R2";
      disp(8'h11, 1, 0, 16'h1111, 1, 0, 16'h2222); step();
      step(); step();

      cur_req = "R3";
      disp(8'h21, 0, 4'd3, 16'h0, 1, 0, 16'h0303); step();
      step(); step();
      bcast(4'd3, 16'hBEEF); step();
      step(); step();

      cur_req = "R4";
      disp(8'h31, 0, 4'd5, 16'h0, 1, 0, 16'h0505); step();
      disp(8'h32, 1, 0, 16'h3232, 1, 0, 16'h3333); step();
      step(); step();
      bcast(4'd5, 16'h5555); step();
      step(); step();

      cur_req = "R5";
      for (int k = 0; k < 4; k++) begin
         disp(8'h41 + 8'(k), 0, 4'd6, 16'h0, 1, 0, 16'h4000 + 16'(k)); step();
      end
      bcast(4'd6, 16'h6666); step();
      step(); step(); step();

      cur_req = "R6";
      disp(8'h51, 0, 4'd7, 16'h0, 0, 4'd7, 16'h0);
      bcast(4'd7, 16'h7777); step();
      step(); step();

      cur_req = "R7";
      for (int k = 0; k < 6; k++) begin
         disp(8'h61 + 8'(k), 0, 4'd8, 16'h0, 1, 0, 16'h6000 + 16'(k)); step();
      end
      disp(8'h67, 1, 0, 16'h6767, 1, 0, 16'h6868); step();
      step();
      bcast(4'd8, 16'h8888); step();
      step(); step(); step(); step();

      cur_req = "R8";
      for (int k = 0; k < 6; k++) begin
         disp(8'h71 + 8'(k), 0, 4'd9, 16'h0, 1, 0, 16'h7000 + 16'(k)); step();
      end
      bcast(4'd9, 16'h9999); step();
      disp(8'h77, 1, 0, 16'h7777, 1, 0, 16'h7878); step();
      disp(8'h78, 1, 0, 16'h7979, 1, 0, 16'h7A7A); step();
      step(); step(); step(); step();

      cur_req = "R9";
      for (int k = 0; k < 4; k++) begin
         disp(8'h81 + 8'(k), 0, 4'd11, 16'h0, 1, 0, 16'h8100 + 16'(k)); step();
      end
      f_v = 1; f_seq = seq - 3;
      disp(8'h85, 1, 0, 16'h8585, 1, 0, 16'h8686); step();
      bcast(4'd11, 16'hB0B0); step();
      step(); step();
      disp(8'h91, 0, 4'd12, 16'h0, 1, 0, 16'h9100); step();
      disp(8'h92, 0, 4'd12, 16'h0, 1, 0, 16'h9200); step();
      bcast(4'd12, 16'hC0C0); step();
      f_v = 1; f_seq = seq - 2; step();
      step(); step();
      drain();

      cur_req = "R10";
      for (int k = 0; k < 12; k++) begin
         disp(8'hA0 + 8'(k), (k % 3) != 0, (k % 2 == 0) ? 4'd13 : 4'd14,
              16'hA000 + 16'(k), 1, 0, 16'hA100 + 16'(k));
         if (k % 4 == 3) bcast(4'd13, 16'hD13 + 16'(k));
         if (k % 4 == 1) bcast(4'd14, 16'hE14 + 16'(k));
         step();
      end
      drain();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule